// File: doc/BRIEF.md
# Memory Bus Fault Capture Unit

This unit sits beside a memory controller that serves two bus masters, a processor and a DMA engine. Each fault the controller reports arrives as a one-cycle strobe. With it come the master that caused it, the direction of the cycle, whether it was an ECC fault, the word address, and the ECC syndrome for the faulting word. The unit keeps the first such fault in an error-address register. For ECC faults it also stores the syndrome in one of two bank halves of a syndrome register. It raises a level interrupt while a fault is held.

Software reads both registers through a small 32-bit port. A write of any value to the error-address register clears the held fault and drops the interrupt. A processor fault that is not ECC means a bus timeout, and a DMA fault that is not ECC means an overrun. An ECC fault with the write flag set means a partial memory write, and one without it means a memory read. For ECC read faults the stored address is skewed forward by the read pipeline, so software must step back to find the faulting word.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset the valid flag is clear, the interrupt is low, and both registers read as zero.
- R2: A fault strobe while no fault is held sets the error-address register at the next clock edge. Bit 31 is valid, bit 30 is processor (1) or DMA (0), bit 29 is write, bit 28 is ECC, and bits 27:0 hold the word address. The interrupt rises at the same edge.
- R3: While the valid flag is set, later fault strobes change neither register (the first error wins).
- R4: A write with `reg_sel` = 0 clears both registers and the valid flag, whatever the data. A fault strobe in the same cycle as that write is captured as a new record.
- R5: For an ECC fault on a read, the stored word address is the faulting address plus 5 in bits 11:0, modulo 4096. Bits 27:12 are unchanged.
- R6: For non-ECC faults and for ECC faults on writes, the stored word address equals the faulting word address.
- R7: An ECC fault stores its syndrome in bits 15:0 of the syndrome register when bit 0 of the faulting word address is 0 (byte-address bit 2 clear). It stores it in bits 31:16 when that bit is 1, and the other half reads zero. Within a half, bit 15 is syndrome-valid, bit 14 is single-error, bits 6:0 are the syndrome, and the rest are zero.
- R8: A non-ECC fault leaves the syndrome register at zero, whatever is on the syndrome inputs.
- R9: A write with `reg_sel` = 1 has no effect on either register.
- R10: The `irq` output equals bit 31 of the error-address register at every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | One-cycle fault report strobe |
| flt_is_cpu | input | 1 | Fault caused by the processor (1) or DMA (0) |
| flt_is_write | input | 1 | Faulting cycle was a write |
| flt_is_ecc | input | 1 | Fault is an ECC error |
| flt_word_addr | input | ADDR_W | Word address of the faulting cycle |
| flt_syn_ok | input | 1 | Syndrome for this fault is valid |
| flt_syn_single | input | 1 | Syndrome marks a single-bit error |
| flt_syn | input | 7 | ECC syndrome of the faulting word |
| reg_sel | input | 1 | Register select: 0 error address, 1 syndrome |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data (content ignored) |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| irq | output | 1 | Level interrupt while a fault is held |

## Verification
A fault strobe or a register write presented before a rising edge shows up on `reg_rdata` and `irq` one edge later. `reg_rdata` follows `reg_sel` in the same cycle with no added delay. The bench drives each stimulus after a falling edge and updates its reference model at the rising edge that consumes it. It then compares both registers and the interrupt a short time after that edge, so each result is checked in the exact cycle it becomes due. Directed cases cover the address wrap, both banks, same-cycle clear and capture, and writes to the syndrome register, and a random stream follows them.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
    localparam int REG_W       = 32;
    localparam int FIELD_W     = 28;
    localparam int SYN_W       = 7;
    localparam int HALF_W      = REG_W / 2;
    localparam int HALF_PAD_W  = HALF_W - 2 - SYN_W;

    localparam logic SEL_ADDR = 1'b0;
    localparam logic SEL_SYN  = 1'b1;

    typedef struct packed {
        logic               valid;
        logic               cpu;
        logic               wr;
        logic               ecc;
        logic [FIELD_W-1:0] addr;
    } ear_t;

    typedef struct packed {
        logic                  ok;
        logic                  single;
        logic [HALF_PAD_W-1:0] pad;
        logic [SYN_W-1:0]      syn;
    } syn_half_t;

    typedef struct packed {
        ear_t      ear;
        syn_half_t hi;
        syn_half_t lo;
    } rec_t;
endpackage

// File: rtl/bfc_addr_adjust.sv
module bfc_addr_adjust #(
    parameter int ADDR_W = 28,
    parameter int LOW_W  = 12,
    parameter int SKEW   = 5
) (
    input  logic [ADDR_W-1:0] word_in,
    input  logic              ecc_read,
    output logic [ADDR_W-1:0] word_out
);
    localparam logic [LOW_W-1:0] SKEW_V = LOW_W'(SKEW);

    logic [LOW_W-1:0] low_skewed;

    generate
        if (ADDR_W > LOW_W) begin : g_split
            always_comb begin
                low_skewed = word_in[LOW_W-1:0] + SKEW_V;
                word_out   = ecc_read ? {word_in[ADDR_W-1:LOW_W], low_skewed} : word_in;
            end
        end else begin : g_flat
            always_comb begin
                low_skewed = LOW_W'(word_in) + SKEW_V;
                word_out   = ecc_read ? ADDR_W'(low_skewed) : word_in;
            end
        end
    endgenerate
endmodule

// File: rtl/bfc_syn_steer.sv
module bfc_syn_steer
    import bfc_pkg::*;
(
    input  logic             bank_hi,
    input  logic             is_ecc,
    input  logic             syn_ok,
    input  logic             syn_single,
    input  logic [SYN_W-1:0] syn,
    output syn_half_t        half_lo,
    output syn_half_t        half_hi
);
    syn_half_t packed_half;

    always_comb begin
        packed_half.ok     = syn_ok;
        packed_half.single = syn_single;
        packed_half.pad    = '0;
        packed_half.syn    = syn;
        half_lo = '0;
        half_hi = '0;
        if (is_ecc) begin
            if (bank_hi) half_hi = packed_half;
            else         half_lo = packed_half;
        end
    end
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
    import bfc_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int LOW_W  = 12,
    parameter int SKEW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic              flt_is_cpu,
    input  logic              flt_is_write,
    input  logic              flt_is_ecc,
    input  logic [ADDR_W-1:0] flt_word_addr,
    input  logic              flt_syn_ok,
    input  logic              flt_syn_single,
    input  logic [SYN_W-1:0]  flt_syn,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam logic [LOW_W-1:0] SKEW_V = LOW_W'(SKEW);

    rec_t              rec_d, rec_q;
    logic [ADDR_W-1:0] adj_word;
    syn_half_t         steer_lo, steer_hi;
    logic              clr_wr;
    logic              take;
    logic              wdata_unused;

    // Content of a write is irrelevant: any write to the address register clears.
    assign wdata_unused = ^reg_wdata;

    bfc_addr_adjust #(
        .ADDR_W (ADDR_W),
        .LOW_W  (LOW_W),
        .SKEW   (SKEW)
    ) addr_adj_i (
        .word_in  (flt_word_addr),
        .ecc_read (flt_is_ecc && !flt_is_write),
        .word_out (adj_word)
    );

    bfc_syn_steer syn_steer_i (
        .bank_hi    (flt_word_addr[0]),
        .is_ecc     (flt_is_ecc),
        .syn_ok     (flt_syn_ok),
        .syn_single (flt_syn_single),
        .syn        (flt_syn),
        .half_lo    (steer_lo),
        .half_hi    (steer_hi)
    );

    always_comb begin
        rec_d  = rec_q;
        clr_wr = reg_wr && (reg_sel == SEL_ADDR);
        take   = flt_valid && (!rec_q.ear.valid || clr_wr);
        if (clr_wr) begin
            rec_d = '0;
        end
        if (take) begin
            rec_d.ear.valid = 1'b1;
            rec_d.ear.cpu   = flt_is_cpu;
            rec_d.ear.wr    = flt_is_write;
            rec_d.ear.ecc   = flt_is_ecc;
            rec_d.ear.addr  = FIELD_W'(adj_word);
            rec_d.lo        = steer_lo;
            rec_d.hi        = steer_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign reg_rdata = (reg_sel == SEL_SYN) ? {rec_q.hi, rec_q.lo} : rec_q.ear;
    assign irq       = rec_q.ear.valid;

    // R2: a fresh fault raises the interrupt at the next edge
    p_capture_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !irq) |=> irq);

    // R3 and R9: a held record does not move unless the address register is written
    p_first_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_sel == SEL_ADDR)) |=> $stable(rec_q));

    // R4: a clear with no new fault leaves the interrupt low
    p_clear_drops_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_ADDR && !flt_valid) |=> !irq);

    // R5: skew of the low field for ECC read faults
    p_read_skew_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !irq && flt_is_ecc && !flt_is_write) |=>
        (rec_q.ear.addr[LOW_W-1:0] == LOW_W'($past(flt_word_addr[LOW_W-1:0]) + SKEW_V)));

    // R7: only the bank chosen by the word-address LSB is loaded
    p_bank_steer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !irq && flt_is_ecc) |=>
        ($past(flt_word_addr[0]) ? (rec_q.lo == '0) : (rec_q.hi == '0)));

    // R8: non-ECC faults leave both syndrome halves clear
    p_no_syn_non_ecc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !irq && !flt_is_ecc) |=> ({rec_q.hi, rec_q.lo} == '0));
endmodule

// File: tb/bus_fault_capture_tb_top.sv
`timescale 1ns/1ps
module bus_fault_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_valid = 1'b0;
    logic        flt_is_cpu = 1'b0;
    logic        flt_is_write = 1'b0;
    logic        flt_is_ecc = 1'b0;
    logic [27:0] flt_word_addr = '0;
    logic        flt_syn_ok = 1'b0;
    logic        flt_syn_single = 1'b0;
    logic [6:0]  flt_syn = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    bit done    = 0;

    logic [31:0] m_addr = '0;
    logic [31:0] m_syn  = '0;

    always #2 clk = ~clk;

    bus_fault_capture dut_i (
        .clk(clk), .rst_n(rst_n),
        .flt_valid(flt_valid), .flt_is_cpu(flt_is_cpu), .flt_is_write(flt_is_write),
        .flt_is_ecc(flt_is_ecc), .flt_word_addr(flt_word_addr),
        .flt_syn_ok(flt_syn_ok), .flt_syn_single(flt_syn_single), .flt_syn(flt_syn),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        bit clr = reg_wr && (reg_sel == 1'b0);
        bit held = m_addr[31];
        logic [27:0] a;
        logic [15:0] half;
        if (!rst_n) begin
            m_addr = '0; m_syn = '0;
            return;
        end
        if (clr) begin
            m_addr = '0; m_syn = '0;
        end
        if (flt_valid && (!held || clr)) begin
            a = flt_word_addr;
            if (flt_is_ecc && !flt_is_write) a = {a[27:12], a[11:0] + 12'd5};
            m_addr = {1'b1, flt_is_cpu, flt_is_write, flt_is_ecc, a};
            half = {flt_syn_ok, flt_syn_single, 7'd0, flt_syn};
            if (!flt_is_ecc)           m_syn = '0;
            else if (flt_word_addr[0]) m_syn = {half, 16'h0};
            else                       m_syn = {16'h0, half};
        end
    endtask

    // Present stimulus (already driven), consume it at the edge, then compare.
    task automatic step(string tag);
        @(posedge clk);
        model_update();
        #1;
        flt_valid = 1'b0; reg_wr = 1'b0;
        reg_sel = 1'b0; #0.2;
        check(tag, "addr reg", reg_rdata, m_addr);
        check("R10", "irq", {31'h0, irq}, {31'h0, m_addr[31]});
        reg_sel = 1'b1; #0.2;
        check(tag, "syn reg", reg_rdata, m_syn);
        @(negedge clk);
    endtask

    task automatic fault(bit cpu, bit wr, bit ecc, logic [27:0] wa,
                         bit ok, bit sg, logic [6:0] s);
        flt_valid = 1'b1; flt_is_cpu = cpu; flt_is_write = wr; flt_is_ecc = ecc;
        flt_word_addr = wa; flt_syn_ok = ok; flt_syn_single = sg; flt_syn = s;
    endtask

    task automatic regwrite(bit sel, logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1'b1;
        @(negedge clk);
        step("R1");

        // processor timeout on a read
        fault(1, 0, 0, 28'h0123456, 1, 1, 7'h4f); step("R2");
        // later faults are held off
        fault(0, 1, 1, 28'h0000777, 1, 0, 7'h2a); step("R3");
        fault(1, 0, 1, 28'h0000002, 1, 1, 7'h11); step("R3");
        // syndrome register write ignored
        regwrite(1, 32'hffffffff); step("R9");
        regwrite(1, 32'h0); fault(0, 0, 1, 28'h3, 1, 1, 7'h7f); step("R9");
        // clear with arbitrary data
        regwrite(0, 32'hdeadbeef); step("R4");
        step("R4");
        // ECC read at the wrap point, even word -> low half
        fault(1, 0, 1, 28'hABCDFFE, 1, 1, 7'h23); step("R5");
        step("R7");
        // clear and capture in the same cycle; ECC partial write, odd word -> high half
        regwrite(0, 32'h0); fault(0, 1, 1, 28'h0000ABB, 1, 0, 7'h0d); step("R4");
        step("R6");
        // DMA overrun on a write with noise on syndrome inputs
        regwrite(0, 32'h1); step("R4");
        fault(0, 1, 0, 28'h7654321, 1, 1, 7'h55); step("R8");
        regwrite(0, 32'h1); step("R4");
        // ECC read, odd word, syndrome not valid
        fault(0, 0, 1, 28'hFFFFFFF, 0, 1, 7'h01); step("R5");
        step("R7");
        regwrite(0, 32'h0); step("R4");
        // ECC read at low field 0xFFA (no wrap reached: 0xFFF)
        fault(1, 0, 1, 28'h0001FFA, 1, 0, 7'h40); step("R5");
        // reset mid-hold
        rst_n = 1'b0; step("R1");
        rst_n = 1'b1;

        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 2) == 0)
                fault($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                      28'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
                      7'($urandom));
            if ($urandom_range(0, 3) == 0)
                regwrite($urandom_range(0, 1), $urandom);
            step("R3");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule